// File: doc/BRIEF.md
# Hypervisor Trap Decoder

This block classifies one instruction per request, issued from a guest running at EL0 or EL1, into one of three outcomes. The outcome is undefined, trap to the hypervisor level (EL2), or proceed. The decision uses the hypervisor's 32-bit configuration word, the current exception level, the non-secure flag and the instruction class. For coprocessor register accesses it also uses the opc1/CRn/CRm/opc2 fields and a pre-decoded register-group code.

The decision logic is combinational. The verdict is captured in a result register, so the result appears one clock after the request. An exception-entry sequencer reads the trap, undef and proceed flags and a small syndrome class code. It does not need to know which configuration bit caused the outcome.

Encodings used throughout:
- Instruction class `instr_cls`:
  - 0: coprocessor access
  - 1: SMC
  - 2: HVC
  - 3: WFE
  - 4: WFI
  - 5: TLB maintenance
  - 6: cache maintenance to the point of unification
  - 7: data cache maintenance by address to the point of coherency
  - 8: data cache maintenance by set/way
  - 9 to 15: no rule applies, so the result is proceed.
- `cur_el`: 0 to 3.
- `reg_group`:
  - 0: other
  - 1: virtual-memory control group
  - 2: cache identification group
  - 3: cache-size selector

Top module: `hyp_trap_decoder`

## Requirements
- R1: When `req_valid` is high at a rising edge, `res_valid` is high after that edge. Otherwise `res_valid`, `res_trap`, `res_undef`, `res_proceed` and `res_syndrome` are all 0 after that edge. A synchronous `rst` clears all outputs to 0.
- R2: Every valid result asserts exactly one of `res_trap`, `res_undef` and `res_proceed`. When an instruction is both undefined and matched by a trap enable, the result is undefined.
- R3: No trap is taken when `non_secure` is 0 or `cur_el` is 2 or 3. Undefined results are unaffected by this gate.
- R4: For a coprocessor access to group 1:
  - A read from EL1 traps when `cfg[30]` is 1.
  - A write from EL1 traps when `cfg[26]` is 1.
  - Any access from EL0 is undefined.
- R5: HVC is undefined at every level when `cfg[29]` is 1. With `cfg[29]` at 0, HVC is undefined from EL0 and proceeds from EL1, EL2 and EL3. HVC never traps.
- R6: The implementation-defined range covers any opc1 and opc2, with:
  - CRn=9 and CRm in {0,1,2,5,6,7,8},
  - CRn=10 and CRm in {0,1,4,8},
  - CRn=11 and CRm in 0..8 or 15.
  
  A coprocessor access in this range is undefined from EL0. From EL1 it traps when `cfg[20]` is 1.
- R7: The ID-register encodings have opc1=0 and CRn=0, with one of:
  - CRm in 3..7 and opc2 in {0,1},
  - CRm=3 and opc2=2,
  - CRm=5 and opc2 in {4,5}.
  
  Any coprocessor access to these is undefined from EL0. A read from EL1 traps when `cfg[18]` is 1.
- R8: With `cfg[17]` at 1, two kinds of access trap from EL0 or EL1: a read of group 2, and any read or write of group 3.
- R9: SMC is undefined from EL0. From EL1 it traps only when both `cfg[19]` and `cond_pass` are 1.
- R10: WFE traps when `cfg[14]` is 1, and WFI traps when `cfg[13]` is 1. In both cases the level must be EL0 or EL1 and `would_suspend` must be 1.
- R11: TLB maintenance (trap bit `cfg[25]`) and set/way maintenance (trap bit `cfg[22]`) are undefined from EL0 and trap only from EL1.
- R12: Point-of-unification maintenance traps from EL0 or EL1 when `cfg[24]` is 1. Point-of-coherency maintenance traps from EL0 or EL1 when `cfg[23]` is 1.
- R13: `res_syndrome` takes these values:
  - 0: proceed
  - 1: undefined
  - 2: coprocessor-access trap
  - 3: SMC trap
  - 4: WFE/WFI trap
  - 5: TLB trap
  - 6: cache-maintenance trap

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| cfg | input | 32 | Effective hypervisor configuration word |
| cur_el | input | 2 | Current exception level |
| non_secure | input | 1 | Requester is in non-secure state |
| instr_cls | input | 4 | Instruction class code |
| is_write | input | 1 | Coprocessor access is a write (0 = read) |
| cond_pass | input | 1 | SMC passed its condition check |
| would_suspend | input | 1 | WFE/WFI would suspend execution |
| reg_group | input | 2 | Pre-decoded register group |
| cp_opc1 | input | 3 | Coprocessor opc1 field |
| cp_crn | input | 4 | Coprocessor CRn field |
| cp_crm | input | 4 | Coprocessor CRm field |
| cp_opc2 | input | 3 | Coprocessor opc2 field |
| res_valid | output | 1 | Result valid |
| res_trap | output | 1 | Trap to EL2 |
| res_undef | output | 1 | Treat as undefined |
| res_proceed | output | 1 | Execute normally |
| res_syndrome | output | 3 | Syndrome class code |

## Verification
The bench aims at the edges of the encoding ranges, such as CRm=3 versus CRm=4 under CRn=10, and CRm=15 versus CRm=14 under CRn=11. A matcher with a wrong mask bit would trap or reject a neighbouring register. It also tests the EL0 privilege rules: with no trap bit set, EL0 must still get undefined for privileged accesses. With all trap bits set, undefined must still win over trap; a design that reversed this priority would send undefined instructions to the hypervisor. Secure requests and requests from EL2 are sent with every enable set, so a missing gate shows up as a spurious trap. SMC with a failed condition and WFE/WFI that would not suspend are also covered, because an ungated enable would trap them.

// File: rtl/hyp_trap_pkg.sv
package hyp_trap_pkg;

  localparam int CFG_W  = 32;
  localparam int CLS_W  = 4;
  localparam int EL_W   = 2;
  localparam int GRP_W  = 2;
  localparam int SYN_W  = 3;

  // configuration word bit positions (behavioural: software writes this layout)
  localparam int B_VM_RD   = 30;
  localparam int B_HVC_OFF = 29;
  localparam int B_VM_WR   = 26;
  localparam int B_TLB     = 25;
  localparam int B_POU     = 24;
  localparam int B_POC     = 23;
  localparam int B_SETWAY  = 22;
  localparam int B_IMPDEF  = 20;
  localparam int B_SMC     = 19;
  localparam int B_ID3     = 18;
  localparam int B_CACHEID = 17;
  localparam int B_WFE     = 14;
  localparam int B_WFI     = 13;

  typedef enum logic [CLS_W-1:0] {
    CLS_CP     = 4'd0,
    CLS_SMC    = 4'd1,
    CLS_HVC    = 4'd2,
    CLS_WFE    = 4'd3,
    CLS_WFI    = 4'd4,
    CLS_TLB    = 4'd5,
    CLS_POU    = 4'd6,
    CLS_POC    = 4'd7,
    CLS_SETWAY = 4'd8
  } instr_cls_e;

  typedef enum logic [GRP_W-1:0] {
    GRP_OTHER   = 2'd0,
    GRP_VMCTL   = 2'd1,
    GRP_CACHEID = 2'd2,
    GRP_CSEL    = 2'd3
  } reg_grp_e;

  typedef enum logic [SYN_W-1:0] {
    SYN_NONE  = 3'd0,
    SYN_UNDEF = 3'd1,
    SYN_CP    = 3'd2,
    SYN_SMC   = 3'd3,
    SYN_WFX   = 3'd4,
    SYN_TLB   = 3'd5,
    SYN_CACHE = 3'd6
  } syn_e;

  typedef struct packed {
    logic vm_rd;
    logic hvc_off;
    logic vm_wr;
    logic tlb;
    logic pou;
    logic poc;
    logic setway;
    logic impdef;
    logic smc;
    logic id3;
    logic cacheid;
    logic wfe;
    logic wfi;
  } trap_en_t;

  typedef struct packed {
    logic trap;
    logic undef;
    syn_e syn;
  } verdict_t;

endpackage

// File: rtl/cp_field_match.sv
module cp_field_match
  import hyp_trap_pkg::*;
(
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output logic       impdef_hit,
  output logic       id3_hit
);

  localparam int N_IMP_ROWS = 3;
  localparam int IMP_CRN0   = 9;

  // one CRm mask per CRn row of the implementation-defined range (bit i = CRm i)
  localparam logic [15:0] IMP_MASK [N_IMP_ROWS] = '{
    16'b0000_0001_1110_0111,   // CRn 9 : 0,1,2,5,6,7,8
    16'b0000_0001_0001_0011,   // CRn 10: 0,1,4,8
    16'b1000_0001_1111_1111    // CRn 11: 0..8,15
  };

  logic [N_IMP_ROWS-1:0] row_hit;

  generate
    for (genvar g = 0; g < N_IMP_ROWS; g++) begin : g_imp_row
      assign row_hit[g] = (crn == 4'(IMP_CRN0 + g)) && IMP_MASK[g][crm];
    end
  endgenerate

  assign impdef_hit = |row_hit;

  logic id_base;
  logic id_blk_a, id_blk_b, id_blk_c;

  assign id_base  = (opc1 == 3'd0) && (crn == 4'd0);
  assign id_blk_a = (crm >= 4'd3) && (crm <= 4'd7) && (opc2 <= 3'd1);
  assign id_blk_b = (crm == 4'd3) && (opc2 == 3'd2);
  assign id_blk_c = (crm == 4'd5) && ((opc2 == 3'd4) || (opc2 == 3'd5));
  assign id3_hit  = id_base && (id_blk_a || id_blk_b || id_blk_c);

endmodule

// File: rtl/trap_rules.sv
module trap_rules
  import hyp_trap_pkg::*;
(
  input  trap_en_t         en,
  input  logic [EL_W-1:0]  cur_el,
  input  logic             non_secure,
  input  logic [CLS_W-1:0] instr_cls,
  input  logic             is_write,
  input  logic             cond_pass,
  input  logic             would_suspend,
  input  logic [GRP_W-1:0] reg_group,
  input  logic             impdef_hit,
  input  logic             id3_hit,
  output verdict_t         verdict
);

  logic at_el0, at_el1, rd, vm_grp;
  logic undef_c, hit_c, may_trap, trap_c;
  syn_e trap_syn;

  assign at_el0   = (cur_el == 2'd0);
  assign at_el1   = (cur_el == 2'd1);
  assign rd       = !is_write;
  assign vm_grp   = (reg_group == GRP_VMCTL);
  assign may_trap = non_secure && !cur_el[1];

  always_comb begin
    undef_c  = 1'b0;
    hit_c    = 1'b0;
    trap_syn = SYN_NONE;
    case (instr_cls)
      CLS_CP: begin
        undef_c  = at_el0 && (vm_grp || id3_hit || impdef_hit);
        hit_c    = (at_el1 && vm_grp && rd && en.vm_rd)
                || (at_el1 && vm_grp && is_write && en.vm_wr)
                || (at_el1 && impdef_hit && en.impdef)
                || (at_el1 && id3_hit && rd && en.id3)
                || (en.cacheid && ((reg_group == GRP_CACHEID && rd)
                                   || reg_group == GRP_CSEL));
        trap_syn = SYN_CP;
      end
      CLS_SMC: begin
        undef_c  = at_el0;
        hit_c    = at_el1 && en.smc && cond_pass;
        trap_syn = SYN_SMC;
      end
      CLS_HVC: begin
        undef_c  = en.hvc_off || at_el0;
      end
      CLS_WFE: begin
        hit_c    = en.wfe && would_suspend;
        trap_syn = SYN_WFX;
      end
      CLS_WFI: begin
        hit_c    = en.wfi && would_suspend;
        trap_syn = SYN_WFX;
      end
      CLS_TLB: begin
        undef_c  = at_el0;
        hit_c    = at_el1 && en.tlb;
        trap_syn = SYN_TLB;
      end
      CLS_POU: begin
        hit_c    = en.pou;
        trap_syn = SYN_CACHE;
      end
      CLS_POC: begin
        hit_c    = en.poc;
        trap_syn = SYN_CACHE;
      end
      CLS_SETWAY: begin
        undef_c  = at_el0;
        hit_c    = at_el1 && en.setway;
        trap_syn = SYN_CACHE;
      end
      default: ;
    endcase
  end

  assign trap_c = may_trap && hit_c && !undef_c;

  always_comb begin
    verdict.trap  = trap_c;
    verdict.undef = undef_c;
    if (undef_c)     verdict.syn = SYN_UNDEF;
    else if (trap_c) verdict.syn = trap_syn;
    else             verdict.syn = SYN_NONE;
  end

endmodule

// File: rtl/hyp_trap_decoder.sv
module hyp_trap_decoder
  import hyp_trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CFG_W-1:0] cfg,
  input  logic [EL_W-1:0]  cur_el,
  input  logic             non_secure,
  input  logic [CLS_W-1:0] instr_cls,
  input  logic             is_write,
  input  logic             cond_pass,
  input  logic             would_suspend,
  input  logic [GRP_W-1:0] reg_group,
  input  logic [2:0]       cp_opc1,
  input  logic [3:0]       cp_crn,
  input  logic [3:0]       cp_crm,
  input  logic [2:0]       cp_opc2,
  output logic             res_valid,
  output logic             res_trap,
  output logic             res_undef,
  output logic             res_proceed,
  output logic [SYN_W-1:0] res_syndrome
);

  trap_en_t en;
  logic     impdef_hit, id3_hit;
  verdict_t verdict;
  logic     unused_cfg_bits;

  assign en.vm_rd   = cfg[B_VM_RD];
  assign en.hvc_off = cfg[B_HVC_OFF];
  assign en.vm_wr   = cfg[B_VM_WR];
  assign en.tlb     = cfg[B_TLB];
  assign en.pou     = cfg[B_POU];
  assign en.poc     = cfg[B_POC];
  assign en.setway  = cfg[B_SETWAY];
  assign en.impdef  = cfg[B_IMPDEF];
  assign en.smc     = cfg[B_SMC];
  assign en.id3     = cfg[B_ID3];
  assign en.cacheid = cfg[B_CACHEID];
  assign en.wfe     = cfg[B_WFE];
  assign en.wfi     = cfg[B_WFI];

  assign unused_cfg_bits = ^{cfg[31], cfg[28:27], cfg[21], cfg[16:15], cfg[12:0]};

  cp_field_match u_match (
    .opc1       (cp_opc1),
    .crn        (cp_crn),
    .crm        (cp_crm),
    .opc2       (cp_opc2),
    .impdef_hit (impdef_hit),
    .id3_hit    (id3_hit)
  );

  trap_rules u_rules (
    .en            (en),
    .cur_el        (cur_el),
    .non_secure    (non_secure),
    .instr_cls     (instr_cls),
    .is_write      (is_write),
    .cond_pass     (cond_pass),
    .would_suspend (would_suspend),
    .reg_group     (reg_group),
    .impdef_hit    (impdef_hit),
    .id3_hit       (id3_hit),
    .verdict       (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_trap     <= 1'b0;
      res_undef    <= 1'b0;
      res_proceed  <= 1'b0;
      res_syndrome <= SYN_NONE;
    end else begin
      res_valid    <= req_valid;
      res_trap     <= req_valid && verdict.trap;
      res_undef    <= req_valid && verdict.undef;
      res_proceed  <= req_valid && !verdict.trap && !verdict.undef;
      res_syndrome <= req_valid ? verdict.syn : SYN_NONE;
    end
  end

endmodule

// File: rtl/hyp_trap_decoder_chk.sv
module hyp_trap_decoder_chk
  import hyp_trap_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [CFG_W-1:0] cfg,
  input logic [EL_W-1:0]  cur_el,
  input logic             non_secure,
  input logic [CLS_W-1:0] instr_cls,
  input logic             cond_pass,
  input logic             would_suspend,
  input logic             res_valid,
  input logic             res_trap,
  input logic             res_undef,
  input logic             res_proceed,
  input logic [SYN_W-1:0] res_syndrome
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!res_valid && !res_trap && !res_undef && !res_proceed
                    && res_syndrome == 3'd0));

  // R2
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($countones({res_trap, res_undef, res_proceed}) == 1));

  // R3
  gate_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (!non_secure || cur_el[1])) |=> !res_trap);

  // R5
  hvc_off_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && instr_cls == 4'd2 && cfg[29]) |=> res_undef);

  // R9
  smc_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && instr_cls == 4'd1 && !cond_pass) |=> !res_trap);

  // R10
  wfx_awake_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (instr_cls == 4'd3 || instr_cls == 4'd4) && !would_suspend)
      |=> !res_trap);

  // R13
  undef_syn_chk: assert property (@(posedge clk) disable iff (rst)
    res_undef |-> res_syndrome == 3'd1);

  // R13
  proceed_syn_chk: assert property (@(posedge clk) disable iff (rst)
    res_proceed |-> res_syndrome == 3'd0);

endmodule

bind hyp_trap_decoder hyp_trap_decoder_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .cfg           (cfg),
  .cur_el        (cur_el),
  .non_secure    (non_secure),
  .instr_cls     (instr_cls),
  .cond_pass     (cond_pass),
  .would_suspend (would_suspend),
  .res_valid     (res_valid),
  .res_trap      (res_trap),
  .res_undef     (res_undef),
  .res_proceed   (res_proceed),
  .res_syndrome  (res_syndrome)
);

// File: tb/hyp_trap_decoder_tb.sv
`timescale 1ns/1ps
module hyp_trap_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] cfg = '0;
  logic [1:0]  cur_el = '0;
  logic        non_secure = 1'b0;
  logic [3:0]  instr_cls = '0;
  logic        is_write = 1'b0;
  logic        cond_pass = 1'b0;
  logic        would_suspend = 1'b0;
  logic [1:0]  reg_group = '0;
  logic [2:0]  cp_opc1 = '0;
  logic [3:0]  cp_crn = '0;
  logic [3:0]  cp_crm = '0;
  logic [2:0]  cp_opc2 = '0;
  logic        res_valid, res_trap, res_undef, res_proceed;
  logic [2:0]  res_syndrome;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hyp_trap_decoder u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cfg(cfg), .cur_el(cur_el),
    .non_secure(non_secure), .instr_cls(instr_cls), .is_write(is_write),
    .cond_pass(cond_pass), .would_suspend(would_suspend), .reg_group(reg_group),
    .cp_opc1(cp_opc1), .cp_crn(cp_crn), .cp_crm(cp_crm), .cp_opc2(cp_opc2),
    .res_valid(res_valid), .res_trap(res_trap), .res_undef(res_undef),
    .res_proceed(res_proceed), .res_syndrome(res_syndrome)
  );

  function automatic bit impl_range(logic [3:0] crn, logic [3:0] crm);
    if (crn == 9)  return crm inside {0, 1, 2, 5, 6, 7, 8};
    if (crn == 10) return crm inside {0, 1, 4, 8};
    if (crn == 11) return (crm <= 8) || (crm == 15);
    return 0;
  endfunction

  function automatic bit id_range(logic [2:0] o1, logic [3:0] crn,
                                  logic [3:0] crm, logic [2:0] o2);
    if (o1 != 0 || crn != 0) return 0;
    if (crm >= 3 && crm <= 7 && o2 <= 1) return 1;
    if (crm == 3 && o2 == 2) return 1;
    if (crm == 5 && (o2 == 4 || o2 == 5)) return 1;
    return 0;
  endfunction

  // expected {trap, undef, syndrome}
  function automatic logic [4:0] expect_of();
    bit u = 0, t = 0;
    logic [2:0] s = 0;
    bit el0 = (cur_el == 0), el1 = (cur_el == 1);
    bit imp = impl_range(cp_crn, cp_crm);
    bit idr = id_range(cp_opc1, cp_crn, cp_crm, cp_opc2);
    case (instr_cls)
      0: begin
        if (el0 && (reg_group == 1 || imp || idr)) u = 1;
        if (el1 && reg_group == 1 && !is_write && cfg[30]) t = 1;
        if (el1 && reg_group == 1 && is_write && cfg[26]) t = 1;
        if (el1 && imp && cfg[20]) t = 1;
        if (el1 && idr && !is_write && cfg[18]) t = 1;
        if (cfg[17] && ((reg_group == 2 && !is_write) || reg_group == 3)) t = 1;
        s = 2;
      end
      1: begin u = el0; t = el1 && cfg[19] && cond_pass; s = 3; end
      2: begin u = cfg[29] || el0; end
      3: begin t = cfg[14] && would_suspend; s = 4; end
      4: begin t = cfg[13] && would_suspend; s = 4; end
      5: begin u = el0; t = el1 && cfg[25]; s = 5; end
      6: begin t = cfg[24]; s = 6; end
      7: begin t = cfg[23]; s = 6; end
      8: begin u = el0; t = el1 && cfg[22]; s = 6; end
      default: ;
    endcase
    if (!non_secure || cur_el >= 2) t = 0;
    if (u) return {1'b0, 1'b1, 3'd1};
    if (t) return {1'b1, 1'b0, s};
    return {1'b0, 1'b0, 3'd0};
  endfunction

  task automatic check_out(string tag, logic [4:0] exp, bit vld);
    logic [5:0] got = {res_valid, res_trap, res_undef, res_proceed, res_syndrome[1:0]};
    logic [2:0] gs = res_syndrome;
    bit e_pr = vld && !exp[4] && !exp[3];
    checks++;
    if (res_valid !== vld || res_trap !== (vld & exp[4]) || res_undef !== (vld & exp[3])
        || res_proceed !== e_pr || gs !== (vld ? exp[2:0] : 3'd0)) begin
      errors++;
      $display("FAIL %s: got v=%0b t=%0b u=%0b p=%0b syn=%0d exp v=%0b t=%0b u=%0b p=%0b syn=%0d (raw %b)",
               tag, res_valid, res_trap, res_undef, res_proceed, gs,
               vld, exp[4], exp[3], e_pr, exp[2:0], got);
    end
  endtask

  task automatic issue(string tag, logic [31:0] c, logic [1:0] el, bit ns,
                       logic [3:0] cls, bit wr, bit cp, bit sus, logic [1:0] grp,
                       logic [2:0] o1, logic [3:0] rn, logic [3:0] rm, logic [2:0] o2);
    logic [4:0] exp;
    @(negedge clk);
    req_valid = 1; cfg = c; cur_el = el; non_secure = ns; instr_cls = cls;
    is_write = wr; cond_pass = cp; would_suspend = sus; reg_group = grp;
    cp_opc1 = o1; cp_crn = rn; cp_crm = rm; cp_opc2 = o2;
    exp = expect_of();
    @(posedge clk); #1;
    check_out(tag, exp, 1'b1);
    req_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: got no completion exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] all_on = 32'hFFFF_FFFF;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 check_out("R1 reset", 5'd0, 1'b0);
    @(negedge clk) rst = 0;
    @(posedge clk); #1 check_out("R1 idle", 5'd0, 1'b0);

    // R5 HVC
    issue("R5 hvc off at EL2", 32'h2000_0000, 2, 1, 2, 0,0,0,0, 0,0,0,0);
    issue("R5 hvc on EL1",     32'h0,         1, 1, 2, 0,0,0,0, 0,0,0,0);
    issue("R5 hvc EL0",        32'h0,         0, 1, 2, 0,0,0,0, 0,0,0,0);
    // R6 implementation-defined range edges
    issue("R6 crn10 crm4 EL1", 32'h0010_0000, 1, 1, 0, 0,0,0,0, 3,10,4,7);
    issue("R6 crn10 crm3 EL1", 32'h0010_0000, 1, 1, 0, 0,0,0,0, 3,10,3,7);
    issue("R6 crn11 crm15",    32'h0010_0000, 1, 1, 0, 1,0,0,0, 0,11,15,0);
    issue("R6 crn11 crm14",    32'h0010_0000, 1, 1, 0, 1,0,0,0, 0,11,14,0);
    issue("R6 EL0 undef",      32'h0,         0, 1, 0, 0,0,0,0, 0,9,8,0);
    // R7 ID encodings
    issue("R7 crm5 opc2 4",    32'h0004_0000, 1, 1, 0, 0,0,0,0, 0,0,5,4);
    issue("R7 opc1 1 miss",    32'h0004_0000, 1, 1, 0, 0,0,0,0, 1,0,5,4);
    issue("R7 crm4 opc2 2",    32'h0004_0000, 1, 1, 0, 0,0,0,0, 0,0,4,2);
    // R4 VM group
    issue("R4 vm read trap",   32'h4000_0000, 1, 1, 0, 0,0,0,1, 0,1,0,0);
    issue("R4 vm write no",    32'h4000_0000, 1, 1, 0, 1,0,0,1, 0,1,0,0);
    issue("R4 vm write trap",  32'h0400_0000, 1, 1, 0, 1,0,0,1, 0,1,0,0);
    issue("R4 vm EL0 undef",   all_on,        0, 1, 0, 0,0,0,1, 0,1,0,0);
    // R8 cache id
    issue("R8 csel write EL0", 32'h0002_0000, 0, 1, 0, 1,0,0,3, 0,0,0,0);
    issue("R8 cacheid write",  32'h0002_0000, 1, 1, 0, 1,0,0,2, 0,0,0,0);
    // R9 SMC
    issue("R9 smc cond fail",  all_on,        1, 1, 1, 0,0,0,0, 0,0,0,0);
    issue("R9 smc trap",       32'h0008_0000, 1, 1, 1, 0,1,0,0, 0,0,0,0);
    // R10 WFx
    issue("R10 wfi awake",     all_on,        0, 1, 4, 0,0,0,0, 0,0,0,0);
    issue("R10 wfi suspend",   32'h0000_2000, 0, 1, 4, 0,0,1,0, 0,0,0,0);
    issue("R10 wfe wrong bit", 32'h0000_2000, 1, 1, 3, 0,0,1,0, 0,0,0,0);
    // R11 / R2 priority
    issue("R11 tlb EL0 R2",    all_on,        0, 1, 5, 0,0,0,0, 0,0,0,0);
    issue("R11 tlb EL1",       32'h0200_0000, 1, 1, 5, 0,0,0,0, 0,0,0,0);
    issue("R11 setway EL1",    32'h0040_0000, 1, 1, 8, 0,0,0,0, 0,0,0,0);
    // R12
    issue("R12 poc EL0",       32'h0080_0000, 0, 1, 7, 0,0,0,0, 0,0,0,0);
    issue("R12 pou EL1",       32'h0100_0000, 1, 1, 6, 0,0,0,0, 0,0,0,0);
    // R3 gating
    issue("R3 secure tlb",     all_on,        1, 0, 5, 0,0,0,0, 0,0,0,0);
    issue("R3 EL2 wfe",        all_on,        2, 1, 3, 0,0,1,0, 0,0,0,0);
    // R13 reserved class
    issue("R13 reserved cls",  all_on,        1, 1, 12, 0,1,1,3, 0,9,0,0);

    // random mix with back-to-back pipelining
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] rn;
      logic [2:0] o1;
      case ($urandom % 5)
        0: rn = 0; 1: rn = 9; 2: rn = 10; 3: rn = 11; default: rn = 4'($urandom);
      endcase
      o1 = ($urandom % 2) ? 3'd0 : 3'($urandom);
      issue("R2 R13 random", $urandom, 2'($urandom), 1'($urandom), 4'($urandom % 10),
            1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
            o1, rn, 4'($urandom), 3'($urandom));
    end

    @(posedge clk); #1 check_out("R1 idle end", 5'd0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule